// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block collects interrupt requests from a fixed set of peripheral modules for a small processor core. It sends every accepted interrupt to one handler address. Each module supplies a level-sensitive request flag and a local enable. The controller holds three software-visible registers: a global enable, a per-module mask and a 16-bit handler address. It also has a fourth, read-only view that lists which modules are currently pending with all their enables set. The handler reads that view to find the source, because all sources share the same handler.

The core tells the controller when it sits at an instruction boundary and gives it the address of the next instruction. When an interrupt is accepted, the controller issues a jump to the handler address and, in the same cycle, a push of that next-instruction address onto the core stack. It then marks itself in service, which blocks any further interrupt until the core signals a return from interrupt. A request that is still pending after the return is taken at the following boundary.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the handler address, global enable, mask and in-service state are all zero, the jump and push outputs are low, and the read port returns zero.
- R2: A write with select 0 loads all 16 bits of the handler address. A read with select 0 then returns the new value.
- R3: No interrupt is accepted while the global enable (bit 0 of the control register, select 1) is 0.
- R4: Module n counts as pending only when its request, its local enable and mask bit n (select 2) are all 1.
- R5: An acceptance raises jump_req and push_req together for exactly one cycle. jump_addr carries the handler address held at the acceptance cycle. push_data carries the next-instruction address sampled in that same cycle.
- R6: An interrupt is accepted only in a cycle where the instruction-boundary input is high.
- R7: Acceptance sets the in-service state, read as bit 1 of the control register. While it is set, no further interrupt is accepted.
- R8: A return-from-interrupt pulse clears the in-service state on the next clock edge. A request still pending is then accepted at the next instruction boundary.
- R9: Bit n of the identification view (select 3) reads 1 exactly when module n is pending as defined in R4. This holds whatever the global enable and in-service state are.
- R10: Writes with select 3 change nothing, and bit 1 of a control write does not change the in-service state.
- R11: The read port returns the register picked by rd_sel one clock after rd_sel is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 8 | Level request flag per module |
| src_local_en | input | 8 | Local enable per module |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_sel | input | 2 | Write select: 0 address, 1 control, 2 mask, 3 identification |
| csr_wr_data | input | 16 | Write data |
| csr_rd_sel | input | 2 | Read select, same encoding as the write select |
| csr_rd_data | output | 16 | Registered read data |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| next_pc | input | 16 | Address of the next instruction |
| reti | input | 1 | Return-from-interrupt pulse |
| jump_req | output | 1 | Branch to handler request |
| jump_addr | output | 16 | Handler address for the branch |
| push_req | output | 1 | Push return address request |
| push_data | output | 16 | Return address to push |
| in_service | output | 1 | Interrupt in service |

## Verification
The acceptance decision is made in the boundary cycle and registered, so jump_req, push_req, jump_addr, push_data and the in-service state all change at the first clock edge after that cycle. A return pulse clears the in-service state at the edge that samples it, so the earliest new acceptance is one boundary later. Reads and register writes each take one edge. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares every output on the next falling edge, where all of these one-edge results have settled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SEL_VEC   = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_IDENT = 2'd3
  } csr_sel_e;

  localparam int CTRL_GEN_BIT = 0;
  localparam int CTRL_INS_BIT = 1;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic [ADDR_W-1:0]  vector_q,
  output logic               gen_q,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vector_q <= '0;
      gen_q    <= 1'b0;
      mask_q   <= '0;
    end else if (wr_en) begin
      case (csr_sel_e'(wr_sel))
        SEL_VEC:  vector_q <= wr_data;
        SEL_CTRL: gen_q    <= wr_data[CTRL_GEN_BIT];
        SEL_MASK: mask_q   <= wr_data[NUM_SRC-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] local_en,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] pending,
  output logic               any_pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign pending[i] = req[i] & local_en[i] & mask[i];
  end
  assign any_pend = |pending;
endmodule

// File: rtl/intc_accept.sv
module intc_accept #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_boundary,
  input  logic              reti,
  input  logic              gen,
  input  logic              any_pend,
  input  logic [ADDR_W-1:0] vector,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              jump_req,
  output logic [ADDR_W-1:0] jump_addr,
  output logic              push_req,
  output logic [ADDR_W-1:0] push_data,
  output logic              in_service
);
  logic accept;
  assign accept = insn_boundary & gen & ~in_service & any_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      jump_req   <= 1'b0;
      push_req   <= 1'b0;
      jump_addr  <= '0;
      push_data  <= '0;
      in_service <= 1'b0;
    end else begin
      jump_req <= accept;
      push_req <= accept;
      if (accept) begin
        jump_addr  <= vector;
        push_data  <= next_pc;
        in_service <= 1'b1;
      end else if (reti) begin
        in_service <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_local_en,
  input  logic               csr_wr_en,
  input  logic [1:0]         csr_wr_sel,
  input  logic [ADDR_W-1:0]  csr_wr_data,
  input  logic [1:0]         csr_rd_sel,
  output logic [ADDR_W-1:0]  csr_rd_data,
  input  logic               insn_boundary,
  input  logic [ADDR_W-1:0]  next_pc,
  input  logic               reti,
  output logic               jump_req,
  output logic [ADDR_W-1:0]  jump_addr,
  output logic               push_req,
  output logic [ADDR_W-1:0]  push_data,
  output logic               in_service
);
  localparam int DATA_W = ADDR_W;

  logic [ADDR_W-1:0]  vector_q;
  logic               gen_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;
  logic               any_pend;

  intc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (csr_wr_en),
    .wr_sel   (csr_wr_sel),
    .wr_data  (csr_wr_data),
    .vector_q (vector_q),
    .gen_q    (gen_q),
    .mask_q   (mask_q)
  );

  intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .req      (src_req),
    .local_en (src_local_en),
    .mask     (mask_q),
    .pending  (pending),
    .any_pend (any_pend)
  );

  intc_accept #(.ADDR_W(ADDR_W)) u_acc (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .reti          (reti),
    .gen           (gen_q),
    .any_pend      (any_pend),
    .vector        (vector_q),
    .next_pc       (next_pc),
    .jump_req      (jump_req),
    .jump_addr     (jump_addr),
    .push_req      (push_req),
    .push_data     (push_data),
    .in_service    (in_service)
  );

  // Registered read port; select 3 is a live view of enabled pending requests.
  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rd_data <= '0;
    end else begin
      case (csr_sel_e'(csr_rd_sel))
        SEL_VEC:  csr_rd_data <= vector_q;
        SEL_CTRL: csr_rd_data <= DATA_W'({in_service, gen_q});
        SEL_MASK: csr_rd_data <= DATA_W'(mask_q);
        default:  csr_rd_data <= DATA_W'(pending);
      endcase
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_boundary,
  input logic              reti,
  input logic              gen,
  input logic              any_pend,
  input logic [ADDR_W-1:0] vector,
  input logic              jump_req,
  input logic [ADDR_W-1:0] jump_addr,
  input logic              in_service
);
  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> $past(gen));

  assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> $past(any_pend));

  assert_addr_R5: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> (jump_addr == $past(vector)));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    jump_req |=> !jump_req);

  assert_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> $past(insn_boundary));

  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> in_service);

  assert_block_R7: assert property (@(posedge clk) disable iff (rst)
    $past(in_service) |-> !jump_req);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(reti) && !jump_req) |-> !in_service);
endmodule

bind vec_irq_ctrl intc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .insn_boundary (insn_boundary),
  .reti          (reti),
  .gen           (gen_q),
  .any_pend      (any_pend),
  .vector        (vector_q),
  .jump_req      (jump_req),
  .jump_addr     (jump_addr),
  .in_service    (in_service)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_req = '0;
  logic [7:0]  src_local_en = '0;
  logic        csr_wr_en = 1'b0;
  logic [1:0]  csr_wr_sel = '0;
  logic [15:0] csr_wr_data = '0;
  logic [1:0]  csr_rd_sel = '0;
  logic [15:0] csr_rd_data;
  logic        insn_boundary = 1'b0;
  logic [15:0] next_pc = '0;
  logic        reti = 1'b0;
  logic        jump_req;
  logic [15:0] jump_addr;
  logic        push_req;
  logic [15:0] push_data;
  logic        in_service;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .src_req(src_req), .src_local_en(src_local_en),
    .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel), .csr_wr_data(csr_wr_data),
    .csr_rd_sel(csr_rd_sel), .csr_rd_data(csr_rd_data),
    .insn_boundary(insn_boundary), .next_pc(next_pc), .reti(reti),
    .jump_req(jump_req), .jump_addr(jump_addr), .push_req(push_req),
    .push_data(push_data), .in_service(in_service)
  );

  // Behavioural reference model
  logic [15:0] m_vec, m_jaddr, m_pdata, m_rd;
  logic [7:0]  m_mask;
  logic        m_gen, m_ins, m_jump;

  always @(posedge clk) begin
    logic [7:0] pend;
    logic acc;
    if (rst) begin
      m_vec = '0; m_mask = '0; m_gen = 0; m_ins = 0; m_jump = 0;
      m_jaddr = '0; m_pdata = '0; m_rd = '0;
    end else begin
      pend = src_req & src_local_en & m_mask;
      acc = insn_boundary && m_gen && !m_ins && (pend != 0);
      case (csr_rd_sel)
        2'd0: m_rd = m_vec;
        2'd1: m_rd = {14'd0, m_ins, m_gen};
        2'd2: m_rd = {8'd0, m_mask};
        default: m_rd = {8'd0, pend};
      endcase
      m_jump = acc;
      if (acc) begin m_jaddr = m_vec; m_pdata = next_pc; m_ins = 1; end
      else if (reti) m_ins = 0;
      if (csr_wr_en) begin
        case (csr_wr_sel)
          2'd0: m_vec = csr_wr_data;
          2'd1: m_gen = csr_wr_data[0];
          2'd2: m_mask = csr_wr_data[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 jump_req", {31'd0, jump_req}, {31'd0, m_jump});
      chk("R5 push_req", {31'd0, push_req}, {31'd0, m_jump});
      if (m_jump) begin
        chk("R5 jump_addr", {16'd0, jump_addr}, {16'd0, m_jaddr});
        chk("R5 push_data", {16'd0, push_data}, {16'd0, m_pdata});
      end
      chk("R7 in_service", {31'd0, in_service}, {31'd0, m_ins});
      chk("R11 rd_data", {16'd0, csr_rd_data}, {16'd0, m_rd});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    csr_wr_en = 1; csr_wr_sel = sel; csr_wr_data = d;
    tick();
    csr_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    csr_rd_sel = sel;
    tick();
    d = csr_rd_data;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 jump_req", {31'd0, jump_req}, 0);
    rd(2'd0, d); chk("R1 vector", {16'd0, d}, 0);
    rd(2'd1, d); chk("R1 control", {16'd0, d}, 0);
    rd(2'd2, d); chk("R1 mask", {16'd0, d}, 0);
    rd(2'd3, d); chk("R1 ident", {16'd0, d}, 0);

    // R2 vector write, R11 read latency
    wr(2'd0, 16'hBEEF);
    rd(2'd0, d); chk("R2 vector readback", {16'd0, d}, 32'hBEEF);

    // R3 global enable off blocks acceptance; R9 ident independent of enable
    wr(2'd2, 16'h00FF);
    src_local_en = 8'hFF; src_req = 8'h04;
    insn_boundary = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R3 no accept while disabled", {31'd0, jump_req}, 0);
    end
    insn_boundary = 0;
    rd(2'd3, d); chk("R9 ident with enable off", {16'd0, d}, 32'h04);

    // R4 mask bit and local enable gate the request
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h00FB);
    insn_boundary = 1;
    tick(); chk("R4 masked source not taken", {31'd0, jump_req}, 0);
    tick(); chk("R4 masked source not taken", {31'd0, jump_req}, 0);
    insn_boundary = 0;
    rd(2'd3, d); chk("R4 ident masked", {16'd0, d}, 0);
    wr(2'd2, 16'h00FF);
    src_local_en = 8'hFB;
    insn_boundary = 1;
    tick(); chk("R4 local enable off not taken", {31'd0, jump_req}, 0);
    insn_boundary = 0;
    src_local_en = 8'hFF;

    // R6 no acceptance away from a boundary
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R6 no accept off boundary", {31'd0, jump_req}, 0);
    end

    // R5 acceptance
    insn_boundary = 1; next_pc = 16'h1234;
    tick();
    insn_boundary = 0;
    chk("R5 jump_req", {31'd0, jump_req}, 1);
    chk("R5 push_req", {31'd0, push_req}, 1);
    chk("R5 jump_addr", {16'd0, jump_addr}, 32'hBEEF);
    chk("R5 push_data", {16'd0, push_data}, 32'h1234);
    tick(); chk("R5 one-cycle pulse", {31'd0, jump_req}, 0);

    // R7 in service blocks further acceptance
    rd(2'd1, d); chk("R7 in-service bit", {16'd0, d}, 32'h3);
    insn_boundary = 1;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R7 blocked while in service", {31'd0, jump_req}, 0);
    end
    insn_boundary = 0;

    // R10 ignored writes
    wr(2'd1, 16'h0001);
    rd(2'd1, d); chk("R10 control write keeps in-service", {16'd0, d}, 32'h3);
    wr(2'd3, 16'h0000);
    rd(2'd3, d); chk("R10 ident write ignored", {16'd0, d}, 32'h04);

    // R8 return clears in service; pending request taken at next boundary
    wr(2'd0, 16'h0C00);
    reti = 1; tick(); reti = 0;
    chk("R8 in-service cleared", {31'd0, in_service}, 0);
    rd(2'd1, d); chk("R8 control after return", {16'd0, d}, 32'h1);
    insn_boundary = 1; next_pc = 16'h2222;
    tick();
    insn_boundary = 0;
    chk("R8 retaken after return", {31'd0, jump_req}, 1);
    chk("R8 new vector used", {16'd0, jump_addr}, 32'h0C00);
    chk("R8 return address", {16'd0, push_data}, 32'h2222);

    // R9 multiple pending bits
    src_req = 8'hA5;
    rd(2'd3, d); chk("R9 ident pattern", {16'd0, d}, 32'hA5);

    // R8 return with request dropped: nothing taken
    src_req = 8'h00;
    reti = 1; tick(); reti = 0;
    insn_boundary = 1;
    tick(); chk("R8 no accept without request", {31'd0, jump_req}, 0);
    insn_boundary = 0;
    tick();
    finish_run();
  end
endmodule